// File: doc/BRIEF.md
# Streaming zero-free frame encoder

This block turns byte frames into a Consistent Overhead Byte Stuffing (COBS) stream. The encoded stream holds no zero byte except one 0x00 that marks the end of each frame. The frames arrive on an 8-bit valid/ready input with a last-byte flag. The encoded bytes leave on an 8-bit valid/ready output, which normally feeds a serial byte transmitter. A receiver can then find frame boundaries by looking for 0x00 alone.

Each group of output begins with a code byte that gives the length of the group. The code byte is sent before the group's data, so the block holds the nonzero bytes of the open group in an internal buffer of up to 254 entries. It emits the group once the group closes. The group closes on an input zero, on reaching 254 nonzero bytes, or at the end of the frame. The input stalls while a group or a delimiter is being sent.

Top module: `cobs_frame_encoder`

## Requirements
- R1: A group closed by an input zero or by the end of a frame is sent as a code byte equal to one plus the count of nonzero bytes in it, followed by those bytes.
- R2: An input byte of value 0x00 is never sent as data. It closes the open group (an empty group gets code 0x01), and the next byte starts a new group.
- R3: A group that collects 254 nonzero bytes is sent at once with code 0xFF and implies no zero. Encoding then continues in a fresh group.
- R4: When the last byte of a frame is zero, the frame gets one extra final code 0x01. When the last byte completes a 254-byte group, no further code byte follows that group.
- R5: Every frame ends with exactly one 0x00 delimiter, and 0x00 appears nowhere else in the output.
- R6: in_ready is low in every cycle in which out_valid is high.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged in the next cycle.
- R8: After a synchronous active-high reset, out_valid is low and in_ready is high.
- R9: Nonzero input bytes come out in input order with none lost or repeated, under any pattern of gaps on in_valid and out_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 8 | Raw frame byte |
| in_valid | input | 1 | in_data is valid |
| in_last | input | 1 | The byte is the last of its frame |
| in_ready | output | 1 | The block accepts a byte this cycle |
| out_data | output | 8 | Encoded byte |
| out_valid | output | 1 | out_data is valid |
| out_ready | input | 1 | The sink takes out_data this cycle |

## Verification
The hardest case to reach from the ports is a frame boundary that coincides with a full group. A frame must be driven whose 254th nonzero byte in a row carries the last flag, or whose zero-valued last byte follows directly after a full group. Only these frames show whether the final code byte is suppressed or added. The stimulus builds such frames deliberately: 254 nonzero bytes, 254 followed by a zero, 253 followed by a zero, and runs longer than 254. It sends them under stalling patterns on both handshakes, so the group-emit and fill phases overlap with backpressure.

// File: rtl/cobs_enc_pkg.sv
package cobs_enc_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PH_FILL  = 2'd0,
        PH_CODE  = 2'd1,
        PH_DATA  = 2'd2,
        PH_DELIM = 2'd3
    } phase_e;
endpackage

// File: rtl/cobs_group_buf.sv
module cobs_group_buf #(
    parameter int DEPTH = 254,
    parameter int AW    = 8,
    parameter int W     = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/cobs_frame_encoder.sv
module cobs_frame_encoder
    import cobs_enc_pkg::*;
#(
    parameter int GROUP_MAX = 254
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready
);
    localparam int CW = $clog2(GROUP_MAX + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(GROUP_MAX);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] wr_cnt;
        logic [CW-1:0] rd_cnt;
        logic          end_f;
        logic          tail;
    } enc_state_t;

    enc_state_t s_q, s_d;
    logic              wr_en;
    logic              grp_done;
    logic [CW-1:0]     wr_inc;
    logic [CW-1:0]     rd_inc;
    logic [BYTE_W-1:0] buf_rd;

    cobs_group_buf #(
        .DEPTH(GROUP_MAX),
        .AW   (CW),
        .W    (BYTE_W)
    ) u_buf (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(s_q.wr_cnt),
        .wr_data(in_data),
        .rd_addr(s_q.rd_cnt),
        .rd_data(buf_rd)
    );

    always_comb begin
        s_d      = s_q;
        wr_en    = 1'b0;
        grp_done = 1'b0;
        wr_inc   = s_q.wr_cnt + CW'(1);
        rd_inc   = s_q.rd_cnt + CW'(1);
        case (s_q.phase)
            PH_FILL: begin
                if (in_valid) begin
                    if (in_data == '0) begin
                        s_d.phase = PH_CODE;
                        s_d.end_f = in_last;
                        s_d.tail  = in_last;
                    end else begin
                        wr_en      = 1'b1;
                        s_d.wr_cnt = wr_inc;
                        if (wr_inc == FULL_CNT || in_last) begin
                            s_d.phase = PH_CODE;
                            s_d.end_f = in_last;
                            s_d.tail  = 1'b0;
                        end
                    end
                end
            end
            PH_CODE: begin
                if (out_ready) begin
                    if (s_q.wr_cnt == '0) begin
                        grp_done = 1'b1;
                    end else begin
                        s_d.phase  = PH_DATA;
                        s_d.rd_cnt = '0;
                    end
                end
            end
            PH_DATA: begin
                if (out_ready) begin
                    s_d.rd_cnt = rd_inc;
                    if (rd_inc == s_q.wr_cnt) begin
                        grp_done = 1'b1;
                    end
                end
            end
            PH_DELIM: begin
                if (out_ready) begin
                    s_d.phase  = PH_FILL;
                    s_d.end_f  = 1'b0;
                    s_d.wr_cnt = '0;
                end
            end
            default: s_d.phase = PH_FILL;
        endcase

        if (grp_done) begin
            s_d.rd_cnt = '0;
            if (s_q.tail) begin
                s_d.phase  = PH_CODE;
                s_d.wr_cnt = '0;
                s_d.tail   = 1'b0;
            end else if (s_q.end_f) begin
                s_d.phase = PH_DELIM;
            end else begin
                s_d.phase  = PH_FILL;
                s_d.wr_cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '{phase: PH_FILL, wr_cnt: '0, rd_cnt: '0, end_f: 1'b0, tail: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        in_ready  = (s_q.phase == PH_FILL);
        out_valid = (s_q.phase != PH_FILL);
        case (s_q.phase)
            PH_CODE:  out_data = BYTE_W'(s_q.wr_cnt) + BYTE_W'(1);
            PH_DATA:  out_data = buf_rd;
            default:  out_data = '0;
        endcase
    end

    // Stall keeps the offered byte
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // An accepted zero closes the group and stalls the input
    assert_zero_closes_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_data == '0) |=> (out_valid && !in_ready));

    // A group never collects more than the full count while filling
    assert_fill_bound_R3: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (s_q.wr_cnt < FULL_CNT));

    // A zero on the output is only ever the delimiter
    assert_zero_only_delim_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_data == '0) |-> (s_q.phase == PH_DELIM));

    // After the delimiter is taken the block accepts input again
    assert_delim_reopens_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_data == '0) |=> (in_ready && !out_valid));
endmodule

// File: tb/sim_cobs_frame_encoder.sv
module sim_cobs_frame_encoder;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] in_data;
    logic       in_valid;
    logic       in_last;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_ready;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic [7:0] frm[$];
    logic [7:0] in_q[$];
    logic       last_q[$];
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    cobs_frame_encoder u0 (
        .clk(clk), .rst(rst),
        .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic void step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endfunction

    // Reference encoder and queueing of one frame held in frm
    task automatic add_frame();
        int code = 1;
        bit newd = 1'b1;
        logic [7:0] seg[$];
        foreach (frm[i]) begin
            in_q.push_back(frm[i]);
            last_q.push_back(i == frm.size() - 1);
            if (frm[i] == 8'h00) begin
                exp_q.push_back(8'(code)); tag_q.push_back("R1");
                foreach (seg[j]) begin exp_q.push_back(seg[j]); tag_q.push_back("R9"); end
                seg.delete(); code = 1; newd = 1'b1;
            end else begin
                code++; seg.push_back(frm[i]); newd = 1'b1;
                if (code == 255) begin
                    exp_q.push_back(8'hFF); tag_q.push_back("R3");
                    foreach (seg[j]) begin exp_q.push_back(seg[j]); tag_q.push_back("R9"); end
                    seg.delete(); code = 1; newd = 1'b0;
                end
            end
        end
        if (newd) begin
            exp_q.push_back(8'(code)); tag_q.push_back("R4");
            foreach (seg[j]) begin exp_q.push_back(seg[j]); tag_q.push_back("R9"); end
        end
        exp_q.push_back(8'h00); tag_q.push_back("R5");
        frm.delete();
    endtask

    // vmode/rmode: 0 always, 1 pseudo-random gaps, 2 three-on one-off
    task automatic run(input int vmode, input int rmode);
        bit   stalled = 1'b0;
        logic [7:0] held = '0;
        int   n = 0;
        while ((in_q.size() != 0 || exp_q.size() != 0) && cycles < 150000) begin
            @(negedge clk);
            cycles++; n++; step_lfsr();
            in_valid  = (in_q.size() != 0) &&
                        (vmode == 0 || (vmode == 1 && lfsr[3]) || (vmode == 2 && n % 4 != 0));
            in_data   = (in_q.size() != 0) ? in_q[0] : 8'h00;
            in_last   = (in_q.size() != 0) ? last_q[0] : 1'b0;
            out_ready = (rmode == 0 || (rmode == 1 && lfsr[7]) || (rmode == 2 && n % 4 != 3));
            #1;
            check(!(out_valid && in_ready), "R6", int'(in_ready), 0);
            if (stalled) check(out_valid && out_data == held, "R7", int'(out_data), int'(held));
            stalled = out_valid && !out_ready;
            held    = out_data;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", int'(out_data), -1);
                end else begin
                    check(out_data == exp_q[0], tag_q[0], int'(out_data), int'(exp_q[0]));
                    void'(exp_q.pop_front()); void'(tag_q.pop_front());
                end
            end
            if (in_valid && in_ready) begin
                void'(in_q.pop_front()); void'(last_q.pop_front());
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_data = '0; in_last = 1'b0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(!out_valid, "R8", int'(out_valid), 0);
        check(in_ready, "R8", int'(in_ready), 1);

        // R2/R4: single zero frame gives 01 01 00
        frm.push_back(8'h00); add_frame();
        // R1: single nonzero byte
        frm.push_back(8'h05); add_frame();
        // R2: consecutive zeros
        repeat (3) frm.push_back(8'h00); add_frame();
        run(0, 0);

        // R3/R4: exactly one full group at frame end, no extra code
        for (int i = 0; i < 254; i++) frm.push_back(8'((i % 255) + 1)); add_frame();
        // R4: full group then trailing zero
        for (int i = 0; i < 254; i++) frm.push_back(8'((i % 255) + 1));
        frm.push_back(8'h00); add_frame();
        // R1: 253 nonzero then zero
        for (int i = 0; i < 253; i++) frm.push_back(8'h77);
        frm.push_back(8'h00); add_frame();
        run(0, 2);

        // R3/R9: longer than one group
        for (int i = 0; i < 300; i++) frm.push_back(8'((i % 255) + 1)); add_frame();
        run(1, 1);

        // R9: incrementing payloads of many lengths, zeros included
        for (int len = 1; len <= 15; len++) begin
            for (int i = 0; i < len; i++) frm.push_back(8'(i));
            add_frame();
        end
        run(2, 1);
        for (int i = 0; i < 600; i++) frm.push_back(8'(i)); add_frame();
        run(1, 2);

        if (cycles >= 150000) check(1'b0, "R9", cycles, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule